// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This block computes the 32-bit effective address of a memory operand in the style of a two-register CISC addressing mode. It takes a base register value and an index register value, a two-bit scale code and a displacement. A form select chooses which of these terms are added. The displacement is either a full 32-bit immediate or an 8-bit immediate that is sign-extended. All sums wrap modulo 2^32.

Each accepted operation produces one result one clock later on registered outputs. For an ordinary memory operand the block raises a memory request alongside the address. In load-effective-address mode it raises a register write-back strobe and returns the address as data, with no memory request. Segmentation, paging and the memory access itself are handled outside this block.

Top module: `agu_top`

## Requirements
- R1: With form code 0 the address is base + displacement; the index and the scale code have no effect.
- R2: With form code 1 the address is base + index, unscaled; the displacement and the scale code have no effect.
- R3: With form code 2 the address is base + (index << scale), where scale codes 0, 1, 2 and 3 shift by 0, 1, 2 and 3 bits, that is factors 1, 2, 4 and 8; the displacement has no effect.
- R4: With form code 3 the address is base + (index << scale) + displacement.
- R5: When the wide-displacement input is 0, only displacement bits 7:0 are used, sign-extended from bit 7; bits 31:8 have no effect.
- R6: When the wide-displacement input is 1, all 32 displacement bits are added.
- R7: All additions and the index shift wrap modulo 2^32, and no overflow indication exists.
- R8: In load-effective-address mode the result raises the write-back strobe, puts the address on the write-back data output as well as the address output, and keeps the memory request low.
- R9: Outside load-effective-address mode a valid result raises the memory request, keeps the write-back strobe low and drives the write-back data to zero.
- R10: The result of an operation accepted with the input valid high appears one clock later with the output valid high; a cycle with the input valid low yields output valid, memory request and write-back strobe low and a zero address one clock later.
- R11: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_sel | input | 2 | Index shift amount, 0 to 3 |
| disp_val | input | 32 | Displacement immediate |
| disp_wide | input | 1 | 1: 32-bit displacement, 0: sign-extended 8-bit |
| form_sel | input | 2 | 0 base+disp, 1 base+index, 2 base+scaled index, 3 base+scaled index+disp |
| lea_mode | input | 1 | Return the address as register data instead of a memory request |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 32 | Effective address |
| mem_req | output | 1 | Memory access request for the address |
| lea_wr | output | 1 | Register write-back strobe for load-effective-address |
| wb_data | output | 32 | Write-back data (the address in load-effective-address mode) |

## Verification
The bench targets a negative 8-bit displacement with junk in bits 31:8, which a design that zero-extends or adds all 32 bits would turn into an address far off the expected one. It drives every scale code with a high-bit index so that a wrong shift amount or a shift that drops the carry-out wraps differently, and feeds junk displacements into forms 1 and 2, where a design that fails to gate the term would add it. Load-effective-address results are checked for a silent memory request or zero write-back data, and idle cycles for a stale valid or request left over from the previous operation.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned SCALE_W = 2;

  typedef enum logic [1:0] {
    FORM_BASE_DISP      = 2'd0,
    FORM_BASE_INDEX     = 2'd1,
    FORM_BASE_SCIDX     = 2'd2,
    FORM_BASE_SCIDX_DSP = 2'd3
  } agu_form_e;

  function automatic logic form_uses_disp(agu_form_e f);
    return (f == FORM_BASE_DISP) || (f == FORM_BASE_SCIDX_DSP);
  endfunction

  function automatic logic form_uses_index(agu_form_e f);
    return (f != FORM_BASE_DISP);
  endfunction

  function automatic logic form_scales_index(agu_form_e f);
    return (f == FORM_BASE_SCIDX) || (f == FORM_BASE_SCIDX_DSP);
  endfunction
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
  parameter int unsigned W        = 32,
  parameter int unsigned NARROW_W = 8
) (
  input  logic         use_disp,
  input  logic         wide,
  input  logic [W-1:0] disp_in,
  output logic [W-1:0] disp_out
);
  localparam int unsigned EXT_W = W - NARROW_W;

  logic [W-1:0] narrow_ext;

  assign narrow_ext = {{EXT_W{disp_in[NARROW_W-1]}}, disp_in[NARROW_W-1:0]};

  always_comb begin
    if (!use_disp)   disp_out = '0;
    else if (wide)   disp_out = disp_in;
    else             disp_out = narrow_ext;
  end

  always_comb begin
    if (!use_disp) a_r2_disp_gated: assert (disp_out == '0);
  end
endmodule

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
  parameter int unsigned W       = 32,
  parameter int unsigned SCALE_W = 2
) (
  input  logic               use_index,
  input  logic               do_scale,
  input  logic [SCALE_W-1:0] scale,
  input  logic [W-1:0]       index_in,
  output logic [W-1:0]       index_out
);
  localparam int unsigned NSHIFT = 1 << SCALE_W;

  logic [W-1:0] shifted [NSHIFT];

  for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
    assign shifted[s] = index_in << s;
  end

  always_comb begin
    if (!use_index)    index_out = '0;
    else if (do_scale) index_out = shifted[scale];
    else               index_out = index_in;
  end

  always_comb begin
    if (use_index && !do_scale) a_r2_unscaled: assert (index_out == index_in);
  end
endmodule

// File: rtl/agu_adder3.sv
module agu_adder3 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum
);
  logic [W-1:0] ab;

  assign ab  = a + b;
  assign sum = ab + c;
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int unsigned W       = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic         lea_in,
  input  logic [W-1:0] addr_in,
  output logic         valid_out,
  output logic [W-1:0] addr_out,
  output logic         req_out,
  output logic         wr_out,
  output logic [W-1:0] data_out
);
  logic         n_valid, n_req, n_wr;
  logic [W-1:0] n_addr, n_data;

  always_comb begin
    n_valid = valid_in;
    n_req   = valid_in && !lea_in;
    n_wr    = valid_in && lea_in;
    n_addr  = valid_in ? addr_in : '0;
    n_data  = n_wr ? addr_in : '0;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_out <= 1'b0;
        req_out   <= 1'b0;
        wr_out    <= 1'b0;
        addr_out  <= '0;
        data_out  <= '0;
      end else begin
        valid_out <= n_valid;
        req_out   <= n_req;
        wr_out    <= n_wr;
        addr_out  <= n_addr;
        data_out  <= n_data;
      end
    end
  end else begin : g_comb
    assign valid_out = n_valid;
    assign req_out   = n_req;
    assign wr_out    = n_wr;
    assign addr_out  = n_addr;
    assign data_out  = n_data;
  end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int unsigned ADDR_W   = agu_pkg::ADDR_W,
  parameter int unsigned SCALE_W  = agu_pkg::SCALE_W,
  parameter int unsigned NARROW_W = 8,
  parameter bit          REG_OUT  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [ADDR_W-1:0]  index_val,
  input  logic [SCALE_W-1:0] scale_sel,
  input  logic [ADDR_W-1:0]  disp_val,
  input  logic               disp_wide,
  input  logic [1:0]         form_sel,
  input  logic               lea_mode,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  eff_addr,
  output logic               mem_req,
  output logic               lea_wr,
  output logic [ADDR_W-1:0]  wb_data
);
  import agu_pkg::*;

  agu_form_e         form;
  logic [ADDR_W-1:0] disp_term, index_term, addr_sum;

  assign form = agu_form_e'(form_sel);

  agu_disp_ext #(.W(ADDR_W), .NARROW_W(NARROW_W)) u_disp (
    .use_disp (form_uses_disp(form)),
    .wide     (disp_wide),
    .disp_in  (disp_val),
    .disp_out (disp_term)
  );

  agu_index_scale #(.W(ADDR_W), .SCALE_W(SCALE_W)) u_index (
    .use_index (form_uses_index(form)),
    .do_scale  (form_scales_index(form)),
    .scale     (scale_sel),
    .index_in  (index_val),
    .index_out (index_term)
  );

  agu_adder3 #(.W(ADDR_W)) u_add (
    .a   (base_val),
    .b   (index_term),
    .c   (disp_term),
    .sum (addr_sum)
  );

  agu_out_stage #(.W(ADDR_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (in_valid),
    .lea_in    (lea_mode),
    .addr_in   (addr_sum),
    .valid_out (out_valid),
    .addr_out  (eff_addr),
    .req_out   (mem_req),
    .wr_out    (lea_wr),
    .data_out  (wb_data)
  );

  a_r8_lea_returns_addr: assert property (@(posedge clk) disable iff (rst)
    lea_wr |-> (wb_data == eff_addr) && !mem_req && out_valid);

  a_r9_req_no_writeback: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> out_valid && !lea_wr && (wb_data == '0));

  if (REG_OUT) begin : g_timing_chk
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

    a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid && !mem_req && !lea_wr && (eff_addr == '0));

    a_r11_reset_clears: assert property (@(posedge clk)
      rst |=> !out_valid && !mem_req && !lea_wr);
  end
endmodule

// File: tb/agu_top_test.sv
module agu_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] base_val, index_val, disp_val;
  logic [1:0]  scale_sel, form_sel;
  logic        disp_wide, lea_mode;
  logic        out_valid, mem_req, lea_wr;
  logic [31:0] eff_addr, wb_data;

  always #2 clk = ~clk;

  agu_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base_val(base_val),
    .index_val(index_val), .scale_sel(scale_sel), .disp_val(disp_val),
    .disp_wide(disp_wide), .form_sel(form_sel), .lea_mode(lea_mode),
    .out_valid(out_valid), .eff_addr(eff_addr), .mem_req(mem_req),
    .lea_wr(lea_wr), .wb_data(wb_data)
  );

  typedef struct {
    int          cyc;
    logic        v;
    logic        lea;
    logic [31:0] addr;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0, cyc = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] model(logic [31:0] b, logic [31:0] i,
      logic [1:0] s, logic [31:0] d, logic w, logic [1:0] f);
    logic [31:0] dx, ix;
    dx = w ? d : {{24{d[7]}}, d[7:0]};
    case (f)
      2'd0:    ix = 32'd0;
      2'd1:    ix = i;
      default: ix = i * (32'd1 << s);
    endcase
    if (f == 2'd1 || f == 2'd2) dx = 32'd0;
    return b + ix + dx;
  endfunction

  task automatic drive(logic v, logic [31:0] b, logic [31:0] i, logic [1:0] s,
      logic [31:0] d, logic w, logic [1:0] f, logic l, string req);
    exp_t e;
    @(negedge clk);
    in_valid = v; base_val = b; index_val = i; scale_sel = s;
    disp_val = d; disp_wide = w; form_sel = f; lea_mode = l;
    e.cyc = cyc; e.v = v; e.lea = l; e.req = req;
    e.addr = v ? model(b, i, s, d, w, f) : 32'd0;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
      exp_t e;
      logic        xreq, xwr;
      logic [31:0] xwb;
      e = exp_q.pop_front();
      xreq = e.v && !e.lea;
      xwr  = e.v && e.lea;
      xwb  = xwr ? e.addr : 32'd0;
      n_chk++;
      if (out_valid !== e.v || eff_addr !== e.addr || mem_req !== xreq ||
          lea_wr !== xwr || wb_data !== xwb) begin
        n_bad++;
        $display("FAIL %s: got v=%b addr=%h req=%b wr=%b wb=%h exp v=%b addr=%h req=%b wr=%b wb=%h",
          e.req, out_valid, eff_addr, mem_req, lea_wr, wb_data,
          e.v, e.addr, xreq, xwr, xwb);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; base_val = 32'hFFFF_FFFF; index_val = 32'h1;
    scale_sel = 2'd3; disp_val = 32'h55; disp_wide = 1'b1; form_sel = 2'd3; lea_mode = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 0 || mem_req !== 0 || lea_wr !== 0 || eff_addr !== 0 || wb_data !== 0) begin
      n_bad++;
      $display("FAIL R11: got v=%b req=%b wr=%b addr=%h wb=%h exp all zero",
        out_valid, mem_req, lea_wr, eff_addr, wb_data);
    end
    in_valid = 1'b0;
    rst = 1'b0;

    // R1 base + disp, index/scale ignored
    drive(1, 32'h0000_1000, 32'hDEAD_BEEF, 2'd3, 32'h0000_0010, 1, 2'd0, 0, "R1");
    drive(1, 32'h0000_1000, 32'h0000_0000, 2'd0, 32'hFFFF_FF00, 1, 2'd0, 0, "R1_R6");
    // R2 base + index, disp and scale ignored
    drive(1, 32'h0000_2000, 32'h0000_0030, 2'd2, 32'h1234_5678, 1, 2'd1, 0, "R2");
    drive(1, 32'h0000_2000, 32'h0000_0030, 2'd3, 32'h0000_00FF, 0, 2'd1, 0, "R2");
    // R3 every scale code, disp ignored
    for (int s = 0; s < 4; s++)
      drive(1, 32'h0001_0000, 32'h0000_0101, 2'(s), 32'h7777_7777, 1, 2'd2, 0, "R3");
    // R4 index*4 + base + 12
    drive(1, 32'h0000_4000, 32'h0000_0005, 2'd2, 32'h0000_000C, 0, 2'd3, 0, "R4");
    drive(1, 32'h0000_4000, 32'h0000_0005, 2'd3, 32'h0001_0000, 1, 2'd3, 0, "R4_R6");
    // R5 narrow disp: negative, junk upper bits
    drive(1, 32'h0000_1000, 32'h0, 2'd0, 32'hABCD_EF80, 0, 2'd0, 0, "R5");
    drive(1, 32'h0000_1000, 32'h0, 2'd0, 32'hFFFF_FF7F, 0, 2'd0, 0, "R5");
    drive(1, 32'h0000_1000, 32'h3, 2'd1, 32'h0000_00FC, 0, 2'd3, 0, "R5");
    // R7 wrap: high-bit index shifted, sum carry-out dropped
    drive(1, 32'hFFFF_FFF0, 32'h8000_0001, 2'd3, 32'h0000_0020, 1, 2'd3, 0, "R7");
    drive(1, 32'hFFFF_FFFF, 32'hC000_0000, 2'd1, 32'h0000_0001, 0, 2'd2, 0, "R7");
    drive(1, 32'h0000_0004, 32'h0, 2'd0, 32'h0000_0080, 0, 2'd0, 0, "R7_R5");
    // R8 load-effective-address in every form
    for (int f = 0; f < 4; f++)
      drive(1, 32'h0040_0000, 32'h0000_0011, 2'd2, 32'hFFFF_FFF0, 0, 2'(f), 1, "R8");
    // R9 / R10 interleaved with idle cycles
    drive(0, 32'h1111_1111, 32'h2, 2'd1, 32'h3, 1, 2'd3, 0, "R10");
    drive(1, 32'h0000_0100, 32'h2, 2'd1, 32'h3, 1, 2'd3, 0, "R9");
    drive(0, 32'h0, 32'h0, 2'd0, 32'h0, 0, 2'd0, 1, "R10");
    drive(1, 32'h0000_0100, 32'h2, 2'd1, 32'h3, 1, 2'd3, 1, "R8_R10");
    drive(0, 32'h0, 32'h0, 2'd0, 32'h0, 0, 2'd0, 0, "R10");
    // sweep of mixed patterns
    for (int k = 0; k < 40; k++)
      drive(1'(k % 5 != 4), 32'h0101_0101 * k, 32'h9E37_79B9 * k, 2'(k), 32'h0000_0083 + k * 32'h1001,
            1'(k / 3), 2'(k / 2), 1'(k % 3 == 0), "R4_sweep");
    drive(0, 32'h0, 32'h0, 2'd0, 32'h0, 0, 2'd0, 0, "R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule